// File: doc/BRIEF.md
# Mailbox Command Decoder and Responder

This block sits at the far end of a word-wide mailbox channel. It takes in framed command packets of 32-bit words, where the first word is a header and the remaining words are arguments. It checks each packet against a small built-in command table. For every command it sends back exactly one response packet. The response starts with a header that echoes the command's ID and carries a status code. Payload words follow the header when the command succeeded.

Five commands are served:
- a no-operation;
- a fixed device identifier;
- a 64-bit chip identifier, sent as two words;
- a user code taken from an input port;
- a voltage readout. Its single argument is a channel bitmask, and the readout returns one word from a sample input array for each channel selected.

Malformed packets get a one-word error response. A packet is malformed when its code is unknown, its argument count is wrong, or its mask is out of range. The block accepts one command at a time. Its command input stays closed until the whole response has been taken by the downstream consumer.

Header layout, used for both directions:

| Bits | Content |
|---|---|
| [31:28] | reserved |
| [27:24] | ID |
| [23] | reserved |
| [22:12] | LENGTH (argument words in a command, payload words in a response) |
| [11] | must be zero |
| [10:0] | command code in a command, status code in a response |

Top module: `mbx_responder`

## Requirements
- R1: A response header has bits [31:28], [23] and [11] at zero. Bits [27:24] equal the command ID. Bits [22:12] hold the number of payload words that follow. Bits [10:0] hold the status, where 0 means success. Reserved bits [31:28] and [23] of the command header have no effect on the response.
- R2: Code 0x000 (no-op) with no arguments and LENGTH 0 returns a header only, with status 0.
- R3: Code 0x010 returns one payload word equal to the `ID_WORD` parameter. Code 0x013 returns one payload word equal to the `usercode` input. Both take no arguments.
- R4: Code 0x012 takes no arguments and returns two payload words from the 64-bit `CHIP_ID` parameter. The low 32 bits come first.
- R5: Code 0x018 takes exactly one argument, a channel mask, where bit n selects channel n. It returns one payload word per set mask bit, in ascending channel order. Each word is `volt_samples[32n+31:32n]`. A zero mask returns a success header with LENGTH 0.
- R6: A command code outside {0x000, 0x010, 0x012, 0x013, 0x018} returns status 3, and the response is the header alone with LENGTH 0.
- R7: Status 4 is returned, as a header alone with LENGTH 0, in three cases: the header LENGTH differs from the number of argument words received; that number differs from the command's table count; or command bit [11] is set.
- R8: A voltage mask with any bit at position NCH or above set returns status 9, as a header alone with LENGTH 0.
- R9: When several faults are present, status 3 takes precedence over status 4, and status 4 takes precedence over status 9.
- R10: `rsp_sop` is high only on the header word, and `rsp_eop` only on the final word. When there is no payload, the header carries both flags. While `rsp_valid` is high and `rsp_ready` is low, the data and both flags hold steady.
- R11: The response header is valid in the cycle after the last command word is accepted. `cmd_ready` is low from that cycle until the cycle after the final response word is accepted, and it is high again in that cycle. After reset, `cmd_ready` is high and `rsp_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Block can take a command word |
| cmd_data | input | 32 | Command word |
| cmd_last | input | 1 | Marks the final word of a command packet |
| rsp_valid | output | 1 | Response word present |
| rsp_ready | input | 1 | Consumer takes the response word |
| rsp_data | output | 32 | Response word |
| rsp_sop | output | 1 | Response word is the header |
| rsp_eop | output | 1 | Response word is the last of the packet |
| usercode | input | 32 | Value returned by the user code command |
| volt_samples | input | 32*NCH | Packed per-channel voltage samples (unsigned, 16 fractional bits) |

## Verification
The hardest cases to reach from the ports are those where the header's LENGTH agrees with the words sent but disagrees with the table, and those where several faults coincide so that only the precedence order decides the status. The bench builds such packets on purpose: it sends extra or missing arguments with a LENGTH that matches them, and it pairs unknown codes and out-of-range masks with wrong counts. The full space of masks on a four-channel configuration, 0 through 31, is swept so that every popcount, every channel order and every out-of-range bit is seen. Half of those sweeps run with a stalling consumer to exercise holding under backpressure.

// File: rtl/mbx_pkg.sv
// Shared definitions for the mailbox responder: header layout, command
// codes, status codes and the per-command argument table.
// Assumes 32-bit words and 11-bit code and length fields.
package mbx_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned FLD_W  = 11;

    localparam logic [FLD_W-1:0] OP_NOOP     = 11'h000;
    localparam logic [FLD_W-1:0] OP_IDWORD   = 11'h010;
    localparam logic [FLD_W-1:0] OP_CHIPID   = 11'h012;
    localparam logic [FLD_W-1:0] OP_USERCODE = 11'h013;
    localparam logic [FLD_W-1:0] OP_VOLT     = 11'h018;

    localparam logic [FLD_W-1:0] ST_OK      = 11'h000;
    localparam logic [FLD_W-1:0] ST_UNKNOWN = 11'h003;
    localparam logic [FLD_W-1:0] ST_BADARGS = 11'h004;
    localparam logic [FLD_W-1:0] ST_BADMASK = 11'h009;

    typedef struct packed {
        logic [3:0]       rsv_top;
        logic [3:0]       id;
        logic             rsv_mid;
        logic [FLD_W-1:0] len;
        logic             zero_bit;
        logic [FLD_W-1:0] code;
    } mbx_hdr_t;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_HDR  = 2'd1,
        PH_PAY  = 2'd2
    } mbx_phase_e;

    // True when the code is one the block serves.
    function automatic logic op_known(input logic [FLD_W-1:0] c);
        return (c == OP_NOOP) || (c == OP_IDWORD) || (c == OP_CHIPID) ||
               (c == OP_USERCODE) || (c == OP_VOLT);
    endfunction

    // Required argument count for a served code.
    function automatic logic [FLD_W-1:0] op_args(input logic [FLD_W-1:0] c);
        return (c == OP_VOLT) ? 11'd1 : 11'd0;
    endfunction

endpackage

// File: rtl/mbx_chan_pick.sv
// Lowest-set-bit selector over the remaining voltage channel mask.
// Gives the index of the lowest set channel and the mask with that bit
// cleared. Assumes a nonzero mask whenever the index is used.
module mbx_chan_pick #(
    parameter int unsigned NCH  = 4,
    localparam int unsigned IDXW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic [NCH-1:0]  mask,
    output logic [IDXW-1:0] idx,
    output logic [NCH-1:0]  rest
);

    logic [NCH:0]   seen;
    logic [NCH-1:0] onehot;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < NCH; g++) begin : g_prefix
        assign onehot[g]  = mask[g] & ~seen[g];
        assign seen[g+1]  = seen[g] | mask[g];
    end

    // Encode the one-hot lowest bit into a binary channel index.
    always_comb begin
        idx = '0;
        for (int i = 0; i < NCH; i++) begin
            if (onehot[i]) idx = idx | IDXW'(i);
        end
    end

    assign rest = mask & ~onehot;

endmodule

// File: rtl/mbx_hdr_check.sv
// Combinational validation of a captured command: decides the status code
// and the number of payload words the response will carry.
// Assumes the header, argument count and first argument are held stable.
module mbx_hdr_check
    import mbx_pkg::*;
#(
    parameter int unsigned NCH = 4
) (
    input  mbx_hdr_t         hdr,
    input  logic [FLD_W-1:0] argcnt,
    input  logic [WORD_W-1:0] arg0,
    output logic [FLD_W-1:0] status,
    output logic [FLD_W-1:0] paylen
);

    localparam logic [WORD_W-1:0] HI_MASK = ~((32'd1 << NCH) - 32'd1);

    logic [FLD_W-1:0] ones;
    logic             mask_bad;
    logic             args_bad;

    // Count selected channels within the implemented range.
    always_comb begin
        ones = '0;
        for (int i = 0; i < NCH; i++) begin
            ones = ones + FLD_W'(arg0[i]);
        end
    end

    assign mask_bad = |(arg0 & HI_MASK);
    assign args_bad = hdr.zero_bit || (hdr.len != argcnt) || (argcnt != op_args(hdr.code));

    // Prioritised status: unknown code, then argument faults, then mask range.
    always_comb begin
        if (!op_known(hdr.code))                 status = ST_UNKNOWN;
        else if (args_bad)                       status = ST_BADARGS;
        else if (hdr.code == OP_VOLT && mask_bad) status = ST_BADMASK;
        else                                     status = ST_OK;
    end

    // Payload size for a successful command.
    always_comb begin
        paylen = '0;
        if (status == ST_OK) begin
            case (hdr.code)
                OP_IDWORD:   paylen = 11'd1;
                OP_CHIPID:   paylen = 11'd2;
                OP_USERCODE: paylen = 11'd1;
                OP_VOLT:     paylen = ones;
                default:     paylen = 11'd0;
            endcase
        end
    end

endmodule

// File: rtl/mbx_rsp_seq.sv
// Response sequencer: emits the header, then the payload words, under
// ready/valid flow control, and reports when it is idle.
// Assumes its command-side inputs stay stable from start until idle.
module mbx_rsp_seq
    import mbx_pkg::*;
#(
    parameter int unsigned NCH      = 4,
    parameter logic [31:0] ID_WORD  = 32'h0000_0000,
    parameter logic [63:0] CHIP_ID  = 64'h0,
    localparam int unsigned IDXW    = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [WORD_W-1:0]     hdr_word,
    input  logic [FLD_W-1:0]      paylen,
    input  logic [FLD_W-1:0]      code,
    input  logic [NCH-1:0]        mask_in,
    input  logic [WORD_W-1:0]     usercode,
    input  logic [NCH*WORD_W-1:0] volt_samples,
    input  logic                  rsp_ready,
    output logic                  rsp_valid,
    output logic [WORD_W-1:0]     rsp_data,
    output logic                  rsp_sop,
    output logic                  rsp_eop,
    output logic                  idle
);

    mbx_phase_e        phase_q;
    logic [FLD_W-1:0]  cnt_q;
    logic [NCH-1:0]    rem_q;
    logic [IDXW-1:0]   ch_idx;
    logic [NCH-1:0]    ch_rest;
    logic [WORD_W-1:0] pay_word;
    logic              fire;

    mbx_chan_pick #(.NCH(NCH)) pick_i (
        .mask (rem_q),
        .idx  (ch_idx),
        .rest (ch_rest)
    );

    // Select the payload word for the current position.
    always_comb begin
        case (code)
            OP_IDWORD:   pay_word = ID_WORD;
            OP_CHIPID:   pay_word = (cnt_q == '0) ? CHIP_ID[31:0] : CHIP_ID[63:32];
            OP_USERCODE: pay_word = usercode;
            OP_VOLT:     pay_word = volt_samples[int'(ch_idx)*WORD_W +: WORD_W];
            default:     pay_word = '0;
        endcase
    end

    assign rsp_valid = (phase_q != PH_IDLE);
    assign rsp_sop   = (phase_q == PH_HDR);
    assign rsp_eop   = ((phase_q == PH_HDR) && (paylen == '0)) ||
                       ((phase_q == PH_PAY) && (cnt_q == paylen - 11'd1));
    assign rsp_data  = (phase_q == PH_HDR) ? hdr_word : pay_word;
    assign idle      = (phase_q == PH_IDLE);
    assign fire      = rsp_valid && rsp_ready;

    // Advance through header and payload words on each accepted transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
            rem_q   <= '0;
        end else begin
            case (phase_q)
                PH_IDLE: if (start) phase_q <= PH_HDR;
                PH_HDR: if (fire) begin
                    cnt_q   <= '0;
                    rem_q   <= mask_in;
                    phase_q <= (paylen == '0) ? PH_IDLE : PH_PAY;
                end
                PH_PAY: if (fire) begin
                    cnt_q <= cnt_q + 11'd1;
                    rem_q <= ch_rest;
                    if (rsp_eop) phase_q <= PH_IDLE;
                end
                default: phase_q <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/mbx_responder.sv
// Mailbox command decoder and responder top. Collects one framed command,
// validates it, and streams back one response packet before taking more.
// Assumes cmd_last marks the final word of each command packet.
module mbx_responder
    import mbx_pkg::*;
#(
    parameter int unsigned NCH     = 4,
    parameter logic [31:0] ID_WORD = 32'h0A1B_2C3D,
    parameter logic [63:0] CHIP_ID = 64'h1122_3344_5566_7788
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  cmd_valid,
    output logic                  cmd_ready,
    input  logic [31:0]           cmd_data,
    input  logic                  cmd_last,
    output logic                  rsp_valid,
    input  logic                  rsp_ready,
    output logic [31:0]           rsp_data,
    output logic                  rsp_sop,
    output logic                  rsp_eop,
    input  logic [31:0]           usercode,
    input  logic [NCH*32-1:0]     volt_samples
);

    localparam logic [FLD_W-1:0] CNT_MAX = '1;

    mbx_hdr_t          hdr_q;
    logic [FLD_W-1:0]  argcnt_q;
    logic [WORD_W-1:0] arg0_q;
    logic              first_q;
    logic              accept;
    logic              seq_idle;
    logic [FLD_W-1:0]  status;
    logic [FLD_W-1:0]  paylen;
    mbx_hdr_t          rsp_hdr;

    assign cmd_ready = seq_idle;
    assign accept    = cmd_valid && cmd_ready;

    // Capture header, first argument and a saturating argument count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hdr_q    <= '0;
            argcnt_q <= '0;
            arg0_q   <= '0;
            first_q  <= 1'b1;
        end else if (accept) begin
            if (first_q) begin
                hdr_q    <= cmd_data;
                argcnt_q <= '0;
                arg0_q   <= '0;
            end else begin
                if (argcnt_q == '0) arg0_q <= cmd_data;
                if (argcnt_q != CNT_MAX) argcnt_q <= argcnt_q + 11'd1;
            end
            first_q <= cmd_last;
        end
    end

    mbx_hdr_check #(.NCH(NCH)) check_i (
        .hdr    (hdr_q),
        .argcnt (argcnt_q),
        .arg0   (arg0_q),
        .status (status),
        .paylen (paylen)
    );

    // Assemble the response header from the echoed ID and the verdict.
    always_comb begin
        rsp_hdr          = '0;
        rsp_hdr.id       = hdr_q.id;
        rsp_hdr.len      = paylen;
        rsp_hdr.code     = status;
    end

    mbx_rsp_seq #(
        .NCH     (NCH),
        .ID_WORD (ID_WORD),
        .CHIP_ID (CHIP_ID)
    ) seq_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (accept && cmd_last),
        .hdr_word     (rsp_hdr),
        .paylen       (paylen),
        .code         (hdr_q.code),
        .mask_in      (arg0_q[NCH-1:0]),
        .usercode     (usercode),
        .volt_samples (volt_samples),
        .rsp_ready    (rsp_ready),
        .rsp_valid    (rsp_valid),
        .rsp_data     (rsp_data),
        .rsp_sop      (rsp_sop),
        .rsp_eop      (rsp_eop),
        .idle         (seq_idle)
    );

endmodule

// File: rtl/mbx_responder_chk.sv
// Protocol checker for the mailbox responder, attached by bind.
// Assumes synchronous active-low reset; checks only port behaviour.
module mbx_responder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        cmd_valid,
    input logic        cmd_ready,
    input logic        cmd_last,
    input logic        rsp_valid,
    input logic        rsp_ready,
    input logic [31:0] rsp_data,
    input logic        rsp_sop,
    input logic        rsp_eop
);

    assert_hdr_reserved_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_sop |-> (rsp_data[31:28] == 4'h0) && !rsp_data[23] && !rsp_data[11]);

    assert_err_header_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_sop && (rsp_data[10:0] != 11'h0) |-> rsp_eop && (rsp_data[22:12] == 11'h0));

    assert_flags_need_valid_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_sop || rsp_eop) |-> rsp_valid);

    assert_hold_stalled_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_data) && $stable(rsp_sop) && $stable(rsp_eop));

    assert_header_follows_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && cmd_ready && cmd_last |=> rsp_valid && rsp_sop);

    assert_closed_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> !cmd_ready);

    assert_reopen_after_eop_R11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid && rsp_ready && rsp_eop |=> cmd_ready && !rsp_valid);

endmodule

bind mbx_responder mbx_responder_chk chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_last  (cmd_last),
    .rsp_valid (rsp_valid),
    .rsp_ready (rsp_ready),
    .rsp_data  (rsp_data),
    .rsp_sop   (rsp_sop),
    .rsp_eop   (rsp_eop)
);

// File: tb/mbx_responder_tb_top.sv
// Self-checking bench: sweeps command codes, IDs, masks and length faults
// on a four-channel build and compares each response word to a model.
module mbx_responder_tb_top;

    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 4;
    localparam logic [31:0] ID_WORD    = 32'hDEAD_0017;
    localparam logic [63:0] CHIP_ID    = 64'hCAFE_F00D_0BAD_BEEF;
    localparam logic [31:0] UCODE      = 32'hA5C3_0F96;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cmd_valid = 1'b0;
    logic              cmd_ready;
    logic [31:0]       cmd_data = '0;
    logic              cmd_last = 1'b0;
    logic              rsp_valid;
    logic              rsp_ready = 1'b0;
    logic [31:0]       rsp_data;
    logic              rsp_sop;
    logic              rsp_eop;
    logic [NCH*32-1:0] volt_samples;

    int checks = 0;
    int errors = 0;

    logic [31:0] exp_w [16];
    int          exp_n;
    logic [31:0] got_w [16];
    logic        got_s [16];
    logic        got_e [16];
    int          got_n;
    logic [31:0] words [8];

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] sample_of(input int n);
        return 32'h0000_4000 * (n + 1) + n;
    endfunction

    for (genvar g = 0; g < NCH; g++) begin : g_samples
        assign volt_samples[g*32 +: 32] = sample_of(g);
    end

    mbx_responder #(
        .NCH     (NCH),
        .ID_WORD (ID_WORD),
        .CHIP_ID (CHIP_ID)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .cmd_data     (cmd_data),
        .cmd_last     (cmd_last),
        .rsp_valid    (rsp_valid),
        .rsp_ready    (rsp_ready),
        .rsp_data     (rsp_data),
        .rsp_sop      (rsp_sop),
        .rsp_eop      (rsp_eop),
        .usercode     (UCODE),
        .volt_samples (volt_samples)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, expv);
        end
    endtask

    function automatic logic [31:0] mk_hdr(input logic [3:0] id, input logic [10:0] len,
                                           input logic [10:0] code);
        return {4'h0, id, 1'b0, len, 1'b0, code};
    endfunction

    // Model of the expected response, from the requirements.
    task automatic model(input logic [31:0] h, input int nargs, input logic [31:0] a0);
        logic [10:0] code;
        logic [10:0] st;
        int          need;
        bit          known;
        code  = h[10:0];
        known = (code == 11'h000) || (code == 11'h010) || (code == 11'h012) ||
                (code == 11'h013) || (code == 11'h018);
        need  = (code == 11'h018) ? 1 : 0;
        if (!known) st = 11'd3;
        else if (h[11] || (int'(h[22:12]) != nargs) || (nargs != need)) st = 11'd4;
        else if ((code == 11'h018) && ((a0 >> NCH) != 0)) st = 11'd9;
        else st = 11'd0;
        exp_n = 1;
        if (st == 11'd0) begin
            case (code)
                11'h010: begin exp_w[1] = ID_WORD; exp_n = 2; end
                11'h012: begin exp_w[1] = CHIP_ID[31:0]; exp_w[2] = CHIP_ID[63:32]; exp_n = 3; end
                11'h013: begin exp_w[1] = UCODE; exp_n = 2; end
                11'h018: for (int c = 0; c < NCH; c++) begin
                    if (a0[c]) begin exp_w[exp_n] = sample_of(c); exp_n++; end
                end
                default: ;
            endcase
        end
        exp_w[0] = mk_hdr(h[27:24], 11'(exp_n - 1), st);
    endtask

    task automatic send(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cmd_valid = 1'b1;
            cmd_data  = words[i];
            cmd_last  = (i == n - 1);
            while (!cmd_ready) @(negedge clk);
            @(posedge clk);
        end
        @(negedge clk);
        cmd_valid = 1'b0;
        cmd_last  = 1'b0;
        chk(rsp_valid && rsp_sop && !cmd_ready, "R11", "header valid after last word",
            {29'h0, rsp_valid, rsp_sop, cmd_ready}, 32'h6);
    endtask

    task automatic recv(input bit stall, input string req);
        int          waited;
        bit          done;
        bit          held;
        logic [31:0] pd;
        logic        ps;
        logic        pe;
        waited = 0; done = 0; held = 0; got_n = 0;
        pd = '0; ps = 0; pe = 0;
        while (!done && waited < 200) begin
            if (waited > 0) @(negedge clk);
            waited++;
            if (held)
                chk(rsp_valid && rsp_data == pd && rsp_sop == ps && rsp_eop == pe, "R10",
                    "stalled word held", rsp_data, pd);
            rsp_ready = stall ? ((waited % 3) != 0) : 1'b1;
            if (rsp_valid && rsp_ready) begin
                if (got_n < 16) begin
                    got_w[got_n] = rsp_data; got_s[got_n] = rsp_sop; got_e[got_n] = rsp_eop;
                end
                got_n++;
                done = rsp_eop;
                held = 0;
            end else if (rsp_valid) begin
                held = 1; pd = rsp_data; ps = rsp_sop; pe = rsp_eop;
            end else begin
                held = 0;
            end
            @(posedge clk);
        end
        @(negedge clk);
        rsp_ready = 1'b0;
        chk(cmd_ready && !rsp_valid, "R11", "reopen after final word",
            {30'h0, cmd_ready, rsp_valid}, 32'h2);
        chk(got_n == exp_n, req, "word count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n && i < 16; i++) begin
            chk(got_w[i] == exp_w[i], req, $sformatf("word %0d", i), got_w[i], exp_w[i]);
            chk(got_s[i] == (i == 0), "R10", $sformatf("sop on word %0d", i), got_s[i], (i == 0));
            chk(got_e[i] == (i == exp_n - 1), "R10", $sformatf("eop on word %0d", i),
                got_e[i], (i == exp_n - 1));
        end
    endtask

    // One command: header, nargs arguments (a0 first, then copies of a1).
    task automatic run(input logic [31:0] h, input int nargs, input logic [31:0] a0,
                       input logic [31:0] a1, input bit stall, input string req);
        words[0] = h;
        for (int i = 1; i <= nargs && i < 8; i++) words[i] = (i == 1) ? a0 : a1;
        model(h, nargs, a0);
        send(nargs + 1);
        recv(stall, req);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual run still busy, expected completion");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(cmd_ready && !rsp_valid, "R11", "reset state", {30'h0, cmd_ready, rsp_valid}, 32'h2);

        // R2 with R1: no-op across every ID, reserved command bits set on odd IDs.
        for (int id = 0; id < 16; id++) begin
            logic [31:0] h;
            h = mk_hdr(4'(id), 11'd0, 11'h000);
            if (id % 2 == 1) h = h | 32'hF080_0000;
            run(h, 0, '0, '0, 1'b0, "R2");
        end

        // R3 and R4: fixed identifier, user code and chip identifier.
        for (int id = 0; id < 16; id += 5) begin
            run(mk_hdr(4'(id), 11'd0, 11'h010), 0, '0, '0, id[0], "R3");
            run(mk_hdr(4'(id), 11'd0, 11'h013), 0, '0, '0, 1'b0, "R3");
            run(mk_hdr(4'(id), 11'd0, 11'h012), 0, '0, '0, id[0], "R4");
        end

        // R5 and R8: every mask over five bits, stalling on odd masks.
        for (int m = 0; m < 32; m++) begin
            run(mk_hdr(4'(m % 16), 11'd1, 11'h018), 1, 32'(m), '0, m[0],
                (m < 16) ? "R5" : "R8");
        end
        run(mk_hdr(4'h7, 11'd1, 11'h018), 1, 32'h8000_0001, '0, 1'b0, "R8");

        // R6: every unknown code in the low range plus the top code.
        for (int c = 0; c < 64; c++) begin
            if (c != 'h00 && c != 'h10 && c != 'h12 && c != 'h13 && c != 'h18)
                run(mk_hdr(4'(c % 16), 11'd0, 11'(c)), 0, '0, '0, 1'b0, "R6");
        end
        run(mk_hdr(4'h3, 11'd0, 11'h7FF), 0, '0, '0, 1'b0, "R6");

        // R7: count faults, both against the header and against the table.
        run(mk_hdr(4'h1, 11'd1, 11'h010), 1, 32'h5, '0, 1'b0, "R7");
        run(mk_hdr(4'h2, 11'd0, 11'h000), 1, 32'h5, '0, 1'b0, "R7");
        run(mk_hdr(4'h3, 11'd1, 11'h018), 0, '0, '0, 1'b0, "R7");
        run(mk_hdr(4'h4, 11'd2, 11'h018), 2, 32'h3, 32'h1, 1'b0, "R7");
        run(mk_hdr(4'h5, 11'd0, 11'h012) | 32'h0000_0800, 0, '0, '0, 1'b0, "R7");
        run(mk_hdr(4'h6, 11'd3, 11'h013), 3, 32'h1, 32'h2, 1'b1, "R7");

        // R9: combined faults resolve by precedence.
        run(mk_hdr(4'h8, 11'd0, 11'h011), 2, 32'h1, 32'h1, 1'b0, "R9");
        run(mk_hdr(4'h9, 11'd2, 11'h018), 2, 32'hF0, 32'h0, 1'b0, "R9");
        run(mk_hdr(4'hA, 11'd1, 11'h018) | 32'h0000_0800, 1, 32'h10, '0, 1'b0, "R9");

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule